// File: doc/BRIEF.md
# Serial Receiver with Acknowledged FIFO

This block is the receive half of a synchronous serial port. An external receive clock and a serial data line are brought into the system clock domain through a two-flop synchroniser, and an edge detector finds the active clock edge. On each active edge one data bit is shifted into a 16-bit shift register. When 16 bits have arrived, the completed word is written into a 32-entry receive FIFO, and shifting carries on with the next bit without a gap.

A host sees the head word at all times on `rd_data`. Reading it has no side effect. The head entry is retired only when the host writes to the acknowledge strobe with data bit 0 set. Because of this, speculative or repeated reads are harmless. The block reports the fill level and a sticky overrun flag. It also raises a level interrupt when the fill level is above a programmable threshold or when an overrun has occurred. A slot-valid input qualifies each word: a word whose final bit is sampled while that input is low is dropped. Shift order, active edge and a half-rate mode (one bit per two receive-clock edges) are selected by static inputs. These inputs are changed only while the receiver is disabled. The system clock runs at least four times faster than the receive clock.

Top module: `srx_ackfifo`

## Requirements
- R1: After reset, `fill` is 0, and `overrun` and `irq` are low.
- R2: While `rx_en` is low, receive-clock edges store nothing. After `rx_en` rises, the first active edge samples bit 0 of a new word.
- R3: With `lsb_first`=0, the first bit received ends up in bit 15 of the word. With `lsb_first`=1, it ends up in bit 0.
- R4: With `fall_edge`=0, data is sampled on rising edges of `sclk_in`. With `fall_edge`=1, data is sampled on falling edges.
- R5: Each completed 16-bit word is written into the FIFO. Words sent back to back are all stored, in arrival order.
- R6: The FIFO holds up to 32 words, and `fill` ranges from 0 to 32.
- R7: A word completed while the FIFO is full is discarded. It sets `overrun`, which stays high until reset.
- R8: `irq` is high exactly when `fill` > `thresh` or `overrun` is high.
- R9: Reading `rd_data` does not change the FIFO. A strobe on `ack_we` with `ack_d0`=0, or a strobe while the FIFO is empty, has no effect.
- R10: A strobe on `ack_we` with `ack_d0`=1 removes the head entry. `fill` and `rd_data` show the change after the next clock edge.
- R11: With `half_rate`=1, only the 1st, 3rd, 5th, ... active edges after enable sample a bit.
- R12: A word whose last bit is sampled while `slot_ok` is low is dropped and does not set `overrun`.
- R13: If a word completes while the FIFO is full, in the same cycle as an acknowledge, the head is removed and the new word is stored, with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| lsb_first | input | 1 | 1 = LSB-first shift order, 0 = MSB-first |
| fall_edge | input | 1 | 1 = sample on falling receive-clock edge, 0 = rising |
| half_rate | input | 1 | 1 = sample on every other active edge |
| thresh | input | 6 | Interrupt threshold on the fill level |
| sclk_in | input | 1 | External receive clock |
| sdata_in | input | 1 | Serial data |
| slot_ok | input | 1 | Slot-valid qualifier for the word being completed |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_d0 | input | 1 | Bit 0 of the acknowledge write data |
| rd_data | output | 16 | Head word of the FIFO |
| fill | output | 6 | Number of stored words |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Level interrupt |

## Verification
A word can be written into the FIFO in the same clock cycle as an acknowledge removes the head entry. This case decides whether a full FIFO overruns or rotates. The bench provokes it by filling all 32 entries and then timing the acknowledge strobe onto the exact cycle in which the last bit of the next word reaches the FIFO. That cycle is three system clocks after the bench's own active receive-clock edge. The result is judged on a flat `fill` of 32, `overrun` staying low, the head advancing to the second word, and the rotated word reading out last during the drain. A behavioural queue model compares `fill`, `overrun`, `irq` and the head word against the design on every clock, alongside directed checks.

// File: rtl/srx_ackfifo.sv
module srx_ackfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_en,
  input  logic                         lsb_first,
  input  logic                         fall_edge,
  input  logic                         half_rate,
  input  logic [$clog2(DEPTH+1)-1:0]   thresh,
  input  logic                         sclk_in,
  input  logic                         sdata_in,
  input  logic                         slot_ok,
  input  logic                         ack_we,
  input  logic                         ack_d0,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         overrun,
  output logic                         irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int BW = $clog2(W);

  logic [2:0]    ck_s;
  logic [1:0]    dt_s;
  logic          ph;
  logic [BW-1:0] bcnt;
  logic [W-1:0]  sr;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          ovr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], sclk_in};
      dt_s <= {dt_s[0], sdata_in};
    end

  wire rise     = ck_s[1] & ~ck_s[2];
  wire fall     = ~ck_s[1] & ck_s[2];
  wire act_edge = rx_en & (fall_edge ? fall : rise);
  wire take     = act_edge & (~half_rate | ~ph);

  wire [W-1:0] nxt_sr = lsb_first ? {dt_s[1], sr[W-1:1]} : {sr[W-2:0], dt_s[1]};
  wire word_done = take & (bcnt == BW'(W-1));
  wire push_req  = word_done & slot_ok;
  wire pop       = ack_we & ack_d0 & (cnt != '0);
  wire full_eff  = (cnt == CW'(DEPTH)) & ~pop;
  wire wr        = push_req & ~full_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph   <= 1'b0;
      bcnt <= '0;
      sr   <= '0;
    end else if (!rx_en) begin
      ph   <= 1'b0;
      bcnt <= '0;
    end else if (act_edge) begin
      if (half_rate) ph <= ~ph;
      if (take) begin
        sr   <= nxt_sr;
        bcnt <= word_done ? '0 : bcnt + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= nxt_sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovr  <= 1'b0;
    end else begin
      if (wr)  wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
      case ({wr, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_req & full_eff) ovr <= 1'b1;
    end

  assign rd_data = mem[rptr];
  assign fill    = cnt;
  assign overrun = ovr;
  assign irq     = (cnt > thresh) | ovr;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovr |=> ovr);
  // R9
  ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !ack_d0 && !push_req) |=> $stable(cnt));
  // R10
  ack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_req) |=> cnt == $past(cnt) - 1'b1);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> cnt <= $past(cnt));
  // R13
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && pop && push_req) |=> (cnt == CW'(DEPTH) && ovr == $past(ovr)));
endmodule

// File: tb/srx_ackfifo_tb.sv
module srx_ackfifo_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic rx_en = 0, lsb_first = 0, fall_edge = 0, half_rate = 0;
  logic [5:0] thresh = 6'd3;
  logic sclk = 0, sdata = 0, slot_ok = 1, ack_we = 0, ack_d0 = 0;
  logic [15:0] rd_data;
  logic [5:0] fill;
  logic overrun, irq;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  srx_ackfifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .lsb_first(lsb_first),
    .fall_edge(fall_edge), .half_rate(half_rate), .thresh(thresh),
    .sclk_in(sclk), .sdata_in(sdata), .slot_ok(slot_ok),
    .ack_we(ack_we), .ack_d0(ack_d0), .rd_data(rd_data),
    .fill(fill), .overrun(overrun), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] q[$];
  logic movr, mph, mvalid;
  int mbc;
  logic [15:0] macc;
  logic mh1, mh2, mh3, md1, md2;
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); movr = 0; mph = 0; mbc = 0; macc = 0; mvalid = 0;
      mh1 = 0; mh2 = 0; mh3 = 0; md1 = 0; md2 = 0;
    end else begin
      logic popn, pushw, edg;
      mvalid = 1;
      pushw = 0;
      popn = ack_we && ack_d0 && q.size() > 0;
      edg = fall_edge ? (!mh2 && mh3) : (mh2 && !mh3);
      if (!rx_en) begin mph = 0; mbc = 0; end
      else if (edg) begin
        if (half_rate && mph) mph = 0;
        else begin
          mph = half_rate;
          macc = lsb_first ? {md2, macc[15:1]} : {macc[14:0], md2};
          if (mbc == 15) begin mbc = 0; pushw = slot_ok; end
          else mbc++;
        end
      end
      if (popn) void'(q.pop_front());
      if (pushw) begin
        if (q.size() < 32) q.push_back(macc);
        else movr = 1;
      end
      mh3 = mh2; mh2 = mh1; mh1 = sclk; md2 = md1; md1 = sdata;
    end
  end

  always @(negedge clk) if (rst_n && mvalid) begin
    chk("R6", fill, q.size(), "model fill");
    chk("R7", overrun, movr, "model overrun");
    chk("R8", irq, (q.size() > thresh) || movr, "model irq");
    if (q.size() > 0) chk("R5", rd_data, q[0], "model head");
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_bit(logic b, logic ack_last);
    sdata = b; sclk = fall_edge; step(4);
    sclk = ~fall_edge; step(2);
    if (ack_last) begin ack_we = 1; ack_d0 = 1; end
    step(1);
    ack_we = 0; ack_d0 = 0;
    step(1);
  endtask

  task automatic send_word(logic [15:0] w, logic ack_last = 0);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = lsb_first ? w[i] : w[15-i];
      if (half_rate) send_bit(b, 0);
      send_bit(b, ack_last && i == 15);
    end
    step(2);
  endtask

  task automatic cfg(logic lf, logic fe, logic hr);
    rx_en = 0; step(1);
    lsb_first = lf; fall_edge = fe; half_rate = hr; sclk = fe;
    step(6);
    rx_en = 1; step(1);
  endtask

  task automatic ack(logic d);
    ack_we = 1; ack_d0 = d; step(1);
    ack_we = 0; ack_d0 = 0;
  endtask

  task automatic drain();
    while (fill != 0) ack(1);
    step(1);
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] w1;
    step(3); rst_n = 1; step(1);
    chk("R1", fill, 0, "reset fill");
    chk("R1", overrun, 0, "reset overrun");
    chk("R1", irq, 0, "reset irq");

    cfg(0, 0, 0);
    send_word(16'hA5C3); send_word(16'h1234);
    chk("R5", fill, 2, "fill after two words");
    chk("R3", rd_data, 16'hA5C3, "msb-first head");
    step(5);
    chk("R9", fill, 2, "read does not pop");
    ack(0);
    chk("R9", fill, 2, "ack with bit0=0 ignored");
    ack(1);
    chk("R10", fill, 1, "ack pops at next edge");
    chk("R10", rd_data, 16'h1234, "head after ack");
    ack(1); ack(1);
    chk("R9", fill, 0, "ack on empty ignored");

    cfg(1, 0, 0);
    send_word(16'h00F1);
    chk("R3", rd_data, 16'h00F1, "lsb-first word");
    drain();

    cfg(0, 1, 0);
    send_word(16'h5A5A);
    chk("R4", rd_data, 16'h5A5A, "falling-edge word");
    drain();

    cfg(0, 0, 1);
    send_word(16'h3C69);
    chk("R11", rd_data, 16'h3C69, "half-rate word");
    drain();

    rx_en = 0; step(1);
    half_rate = 0;
    send_word(16'hFFFF);
    chk("R2", fill, 0, "edges ignored while disabled");

    cfg(0, 0, 0);
    slot_ok = 0;
    send_word(16'hBEEF);
    chk("R12", fill, 0, "invalid slot word dropped");
    chk("R12", overrun, 0, "invalid slot no overrun");
    slot_ok = 1;

    for (int i = 0; i < 32; i++) begin
      send_word(16'h1000 + 16'(i * 3));
      if (i == 2) chk("R8", irq, 0, "irq off at fill=thresh");
      if (i == 3) chk("R8", irq, 1, "irq on at fill>thresh");
    end
    chk("R6", fill, 32, "fifo full");
    send_word(16'hC0DE, 1);
    chk("R13", fill, 32, "push with ack when full");
    chk("R13", overrun, 0, "no overrun on same-cycle ack");
    chk("R13", rd_data, 16'h1003, "head advanced");
    send_word(16'hDEAD);
    chk("R7", fill, 32, "overrun word dropped");
    chk("R7", overrun, 1, "overrun set");
    chk("R7", irq, 1, "irq on overrun");
    chk("R7", rd_data, 16'h1003, "head unchanged by overrun");
    for (int i = 1; i < 32; i++) begin
      chk("R10", rd_data, 16'h1000 + 16'(i * 3), "drain order");
      ack(1);
    end
    chk("R13", rd_data, 16'hC0DE, "rotated word last");
    ack(1);
    chk("R7", fill, 0, "drained");
    chk("R7", irq, 1, "overrun sticky keeps irq");
    step(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule